// File: doc/BRIEF.md
# Machine State Register Update Unit

This block holds a 64-bit machine state register and works out its next value when a move-to operation writes it. A write is not a plain load. Some bits take a value that combines two operand bits. Two bits are masked by a guard that comes from the register's current contents. A one-bit flag can limit the update to just two bits. There are two move-to forms. The word form leaves the upper half of the register alone. The doubleword form also writes most of the upper half. A move-from operation returns the register value and leaves it unchanged.

Bit numbers in this brief count from the most significant end, so bit 0 is the MSB and bit 63 is the LSB. Bit k is therefore `msrOut[63-k]` on the port. Each update finishes in one clock: the new value appears on `msrOut` on the edge that samples the write strobe.

Top module: `msr_update_unit`

## Requirements
- R1: A synchronous active-high `rst` loads the parameter `RESET_VAL` (default all zeros) into the register. The result is visible on `msrOut` after that edge.
- R2: On a move-to with `lFlag`=0 (either form), new bit 48 is operand bit 48 OR operand bit 49.
- R3: On a move-to with `lFlag`=0, new bit 58 is (operand 58 OR operand 49) AND NOT guard, and new bit 59 follows the same rule with operand bit 59. The guard is current bit 3 AND current bit 41 AND NOT operand bit 49, taken from the register value before the write.
- R4: The word move-to (`opSel`=2'b01) with `lFlag`=0 copies operand bits 32-40, 42-47, 49-50, 52-57 and 60-62 into the same positions. Bits 0-31 keep their values.
- R5: The doubleword move-to (`opSel`=2'b10) with `lFlag`=0 copies operand bits 0-2 and 4-40 into the same positions, in addition to the fields listed in R4.
- R6: Bits 3, 41, 51 and 63 are never changed by any move-to. Only reset changes them.
- R7: With `lFlag`=1, either move-to form copies operand bits 48 and 62 and keeps every other bit.
- R8: The register changes only when `wrEn`=1 and `opSel` selects a move-to. A move-from (`opSel`=2'b11), the idle code (2'b00), or `wrEn`=0 leaves it unchanged, and `msrOut` always shows the full current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Operation strobe, sampled on the rising edge |
| opSel | input | 2 | 00 idle, 01 word move-to, 10 doubleword move-to, 11 move-from |
| lFlag | input | 1 | Restricts a move-to to bits 48 and 62 |
| srcVal | input | 64 | Source operand, MSB-first numbering |
| msrOut | output | 64 | Current register value, also the move-from result |

## Verification
The register value is always visible on `msrOut`, so a wrong merge shows up on the port in the cycle right after the faulty write. A corrupted guard input, such as bit 3 or bit 41, shows up later: it only appears at the first `lFlag`=0 write that has operand bit 49 clear. For this reason the bench runs two instances, one with those guard bits clear at reset and one with them set. Each output is compared against a bit-by-bit behavioural model on every clock.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    OP_IDLE     = 2'b00,
    OP_MT_WORD  = 2'b01,
    OP_MT_DWORD = 2'b10,
    OP_MF       = 2'b11
  } msrOp_e;

  typedef struct packed {
    logic mergeWord;
    logic mergeDword;
    logic mergePair;
  } msrStrobe_t;

  // convert MSB-first architectural index to vector index
  function automatic int hwIdx(input int msbIdx);
    return XLEN - 1 - msbIdx;
  endfunction
endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] opSel,
  input  logic       lFlag,
  output msrStrobe_t strb
);
  msrOp_e opCode;

  assign opCode = msrOp_e'(opSel);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (opCode)
        OP_MT_WORD: begin
          strb.mergePair = lFlag;
          strb.mergeWord = !lFlag;
        end
        OP_MT_DWORD: begin
          strb.mergePair  = lFlag;
          strb.mergeDword = !lFlag;
        end
        default: strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/msr_dpath.sv
module msr_dpath
  import msr_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  msrStrobe_t      strb,
  input  logic [XLEN-1:0] srcVal,
  output logic [XLEN-1:0] msrQ
);
  localparam int H3  = hwIdx(3);
  localparam int H41 = hwIdx(41);
  localparam int H48 = hwIdx(48);
  localparam int H49 = hwIdx(49);
  localparam int H51 = hwIdx(51);
  localparam int H58 = hwIdx(58);
  localparam int H59 = hwIdx(59);
  localparam int H62 = hwIdx(62);
  localparam int H63 = hwIdx(63);

  function automatic logic [XLEN-1:0] copyMask(input logic upperToo);
    logic [XLEN-1:0] m;
    m = '0;
    for (int k = 0; k < XLEN; k++) begin
      if ((k >= 32 && k <= 40) || (k >= 42 && k <= 47) || (k >= 49 && k <= 50) ||
          (k >= 52 && k <= 57) || (k >= 60 && k <= 62))
        m[hwIdx(k)] = 1'b1;
      if (upperToo && ((k >= 0 && k <= 2) || (k >= 4 && k <= 31)))
        m[hwIdx(k)] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [XLEN-1:0] WORD_MASK  = copyMask(1'b0);
  localparam logic [XLEN-1:0] DWORD_MASK = copyMask(1'b1);
  localparam logic [XLEN-1:0] PAIR_MASK  = (XLEN'(1) << H48) | (XLEN'(1) << H62);

  logic            guardOn;
  logic            fullMerge;
  logic [XLEN-1:0] selMask;
  logic [XLEN-1:0] nextVal;

  assign guardOn   = msrQ[H41] & msrQ[H3] & ~srcVal[H49];
  assign fullMerge = strb.mergeWord | strb.mergeDword;
  assign selMask   = strb.mergeDword ? DWORD_MASK : WORD_MASK;

  always_comb begin
    nextVal = msrQ;
    if (strb.mergePair) begin
      nextVal = (msrQ & ~PAIR_MASK) | (srcVal & PAIR_MASK);
    end else if (fullMerge) begin
      nextVal      = (msrQ & ~selMask) | (srcVal & selMask);
      nextVal[H48] = srcVal[H48] | srcVal[H49];
      nextVal[H58] = (srcVal[H58] | srcVal[H49]) & ~guardOn;
      nextVal[H59] = (srcVal[H59] | srcVal[H49]) & ~guardOn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) msrQ <= RESET_VAL;
    else     msrQ <= nextVal;
  end

  // R1
  reset_load_chk: assert property (@(posedge clk) rst |=> msrQ == RESET_VAL);

  // R2
  or_merge_chk: assert property (@(posedge clk) disable iff (rst)
    fullMerge |=> msrQ[H48] == ($past(srcVal[H48]) | $past(srcVal[H49])));

  // R3
  guard_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fullMerge && msrQ[H3] && msrQ[H41] && !srcVal[H49]) |=> (!msrQ[H58] && !msrQ[H59]));

  // R6
  fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($stable(msrQ[H3]) && $stable(msrQ[H41]) && $stable(msrQ[H51]) && $stable(msrQ[H63])));

  // R7
  pair_only_chk: assert property (@(posedge clk) disable iff (rst)
    strb.mergePair |=> ((msrQ ^ $past(msrQ)) & ~PAIR_MASK) == '0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb == '0) |=> $stable(msrQ));
endmodule

// File: rtl/msr_update_unit.sv
module msr_update_unit
  import msr_pkg::*;
#(
  parameter logic [63:0] RESET_VAL = '0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [1:0]  opSel,
  input  logic        lFlag,
  input  logic [63:0] srcVal,
  output logic [63:0] msrOut
);
  msrStrobe_t strb;

  msr_ctrl ctrl_i (
    .wrEn  (wrEn),
    .opSel (opSel),
    .lFlag (lFlag),
    .strb  (strb)
  );

  msr_dpath #(.RESET_VAL(RESET_VAL)) dpath_i (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .srcVal (srcVal),
    .msrQ   (msrOut)
  );
endmodule

// File: tb/msr_update_unit_tb.sv
`timescale 1ns/1ps
module msr_update_unit_tb_top;
  localparam logic [63:0] RST_B = 64'h1000_0000_0040_1001; // bits 3,41,51,63 set

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic        lFlag = 1'b0;
  logic [63:0] srcVal = '0;
  logic [63:0] outA, outB;
  logic [63:0] expA, expB;
  int          nRun = 0;
  int          nFail = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  msr_update_unit dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .opSel(opSel), .lFlag(lFlag),
    .srcVal(srcVal), .msrOut(outA));

  msr_update_unit #(.RESET_VAL(RST_B)) dutB_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .opSel(opSel), .lFlag(lFlag),
    .srcVal(srcVal), .msrOut(outB));

  function automatic logic getB(input logic [63:0] v, input int k);
    return v[63-k];
  endfunction

  function automatic logic [63:0] refNext(input logic [63:0] cur, input logic w,
      input logic [1:0] op, input logic l, input logic [63:0] s);
    logic [63:0] n;
    logic inWord, inUpper, g;
    n = cur;
    if (!w || !(op == 2'b01 || op == 2'b10)) return cur;
    if (l) begin
      n[63-48] = getB(s, 48);
      n[63-62] = getB(s, 62);
      return n;
    end
    g = getB(cur, 3) && getB(cur, 41) && !getB(s, 49);
    for (int k = 0; k < 64; k++) begin
      inWord  = (k inside {[32:40], [42:47], [49:50], [52:57], [60:62]});
      inUpper = (k inside {[0:2], [4:31]});
      if (inWord || (op == 2'b10 && inUpper)) n[63-k] = getB(s, k);
      if (k == 48) n[63-k] = getB(s, 48) | getB(s, 49);
      if (k == 58 || k == 59) n[63-k] = (getB(s, k) | getB(s, 49)) & !g;
    end
    return n;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic applyOp(input logic w, input logic [1:0] op, input logic l,
      input logic [63:0] s, input string tag);
    @(negedge clk);
    wrEn = w; opSel = op; lFlag = l; srcVal = s;
    @(posedge clk);
    expA = refNext(expA, w, op, l, s);
    expB = refNext(expB, w, op, l, s);
    #1;
    check({tag, " dutA"}, outA, expA);
    check({tag, " dutB"}, outB, expB);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expA = '0; expB = RST_B;
    #1;
    check("R1 reset A", outA, 64'h0);
    check("R1 reset B", outB, RST_B);
    // R2: only operand bit 49 set forces bit 48
    applyOp(1, 2'b01, 0, 64'h1 << (63-49), "R2 or48");
    // R3: guard from bits 3/41 clears 58,59 in dutB only
    applyOp(1, 2'b01, 0, ~(64'h1 << (63-49)), "R3 guard");
    // R4: word form all ones / zeros
    applyOp(1, 2'b01, 0, '1, "R4 word ones");
    applyOp(1, 2'b01, 0, '0, "R4 word zeros");
    // R5: doubleword form
    applyOp(1, 2'b10, 0, '1, "R5 dword ones");
    // R6: fixed bits after zero dword
    applyOp(1, 2'b10, 0, '0, "R6 fixed zeros");
    applyOp(1, 2'b10, 0, 64'hA5A5_5A5A_F0F0_0F0F, "R6 fixed pattern");
    // R7: L flag narrows update
    applyOp(1, 2'b01, 1, '1, "R7 pair word");
    applyOp(1, 2'b10, 1, '0, "R7 pair dword");
    applyOp(1, 2'b10, 1, 64'h0000_0000_0000_8002, "R7 pair bits");
    // R8: no side effects
    applyOp(1, 2'b11, 0, '1, "R8 move-from");
    applyOp(0, 2'b10, 0, '1, "R8 strobe low");
    applyOp(1, 2'b00, 0, '1, "R8 idle code");
    for (int i = 0; i < 600; i++) begin
      applyOp(1'($urandom), 2'($urandom), 1'($urandom),
              {$urandom, $urandom}, "random R2 R3 R4 R5 R7");
    end
    finish();
  end
endmodule